// File: doc/BRIEF.md
# Cascadable Serial Configuration Shift-Latch

This block receives a configuration word over a three-wire serial link and presents it as a parallel value to the pulse timing logic beside it. While the load enable is high, each rising edge of the serial clock moves one bit into a shift register. The bit that was at the top of that register leaves on the serial output at the same time. A downstream unit can therefore take its serial input from this output, so one serial port can load a whole row of units.

The parallel output comes from a holding latch, not from the shift register. A new word can be shifted in while the timing logic keeps using the old one. The word takes effect only when the enable falls, and the timing logic picks it up from its next trigger. The serial clock, enable and data lines are asynchronous to the system clock. They pass through a two-stage synchronizer before any edge is detected.

A small controller has three states:
- `ST_IDLE`: the enable is low and nothing happens.
- `ST_LOAD`: the enable is high and each detected serial clock rise shifts one bit.
- `ST_COMMIT`: a one-cycle state in which the latch copies the shift register.

The transitions are:
- `ST_IDLE`→`ST_LOAD` when the enable is seen high.
- `ST_LOAD`→`ST_COMMIT` when the enable is seen low.
- `ST_COMMIT`→`ST_LOAD` if the enable is already high again, otherwise `ST_COMMIT`→`ST_IDLE`.

Top module: `cfg_shift_latch`

## Requirements
- R1: During and after reset, until a commit happens, `cfg_word` is all zeros and `ser_out` is 0.
- R2: Bits enter most-significant first. After exactly WIDTH bits and a commit, the first bit sent is at bit WIDTH-1 of `cfg_word` and the last bit sent is at bit 0.
- R3: Before each serial clock rise, `ser_out` equals the current top bit of the shift register. The earlier contents therefore leave most-significant first as new bits enter.
- R4: `cfg_word` does not change while bits are being shifted with the enable high.
- R5: A serial clock rise that is synchronized while the enable is low shifts nothing. `ser_out` stays steady, and a later commit with no bits in between returns the unchanged contents.
- R6: After `ser_en` goes low, `cfg_word` takes the shift register value on the fourth rising edge of `clk`. It is unchanged after the third edge.
- R7: In a chain of N units, where each `ser_out` drives the next unit's `ser_in`, sending N×WIDTH bits loads each unit with its own WIDTH-bit group. The group for the unit furthest from the source is sent first.
- R8: If a serial clock rise and the enable fall reach the synchronized domain in the same cycle, that rise is dropped. The committed word is the one shifted before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_en | input | 1 | Load enable; a falling edge commits the word |
| ser_in | input | 1 | Serial data, most-significant bit first |
| ser_out | output | 1 | Top bit of the shift register, feeds the next unit |
| cfg_word | output | WIDTH | Latched parallel configuration word |

## Verification
The shift and the commit can fall in the same system cycle. This happens when a serial clock rise and the enable fall arrive at the synchronizer outputs together. The bench provokes this case by changing both inputs at the same clock edge on the final bit of a load. It then compares every unit's committed word with a bench model of the chain that did not take that bit. The bench also checks the exact cycle of the commit, so a latch that fires one cycle early or late is caught.

// File: rtl/cfg_sl_pkg.sv
package cfg_sl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_COMMIT = 2'd2
    } ctrl_state_t;

    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/cfg_sl_sync.sv
module cfg_sl_sync #(
    parameter int unsigned BITS   = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BITS-1:0] async_in,
    output logic [BITS-1:0] sync_out
);

    logic [BITS-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/cfg_sl_ctrl.sv
module cfg_sl_ctrl
    import cfg_sl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic en_s,
    output logic shift_en,
    output logic latch_en
);

    ctrl_state_t state_q, state_d;
    logic        sclk_prev_q;
    logic        sclk_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev_q <= 1'b0;
        else        sclk_prev_q <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (en_s)  state_d = ST_LOAD;
            ST_LOAD:   if (!en_s) state_d = ST_COMMIT;
            ST_COMMIT: state_d = en_s ? ST_LOAD : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        shift_en = 1'b0;
        latch_en = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_LOAD:   shift_en = en_s & sclk_rise;
            ST_COMMIT: latch_en = 1'b1;
            default:   ;
        endcase
    end

    // R6: a commit lasts a single cycle and always follows a load
    p_commit_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |=> (state_q != ST_COMMIT));
    p_commit_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |-> ($past(state_q) == ST_LOAD));
    // R8: never shift in the commit cycle
    p_no_shift_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |-> !shift_en);

endmodule

// File: rtl/cfg_sl_shreg.sv
module cfg_sl_shreg #(
    parameter int unsigned WIDTH = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [WIDTH-1:0] shreg_q,
    output logic             dout
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        shreg_q <= '0;
        else if (shift_en) shreg_q <= {shreg_q[WIDTH-2:0], din};
    end

    assign dout = shreg_q[WIDTH-1];

    // R5: contents hold when no shift is requested
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(shreg_q));
    // R2: a new bit enters at the bottom
    p_lsb_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (shreg_q[0] == $past(din)));
    // R3: older bits move towards the serial output
    p_out_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (dout == $past(shreg_q[WIDTH-2])));

endmodule

// File: rtl/cfg_shift_latch.sv
module cfg_shift_latch #(
    parameter int unsigned WIDTH = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_en,
    input  logic             ser_in,
    output logic             ser_out,
    output logic [WIDTH-1:0] cfg_word
);

    localparam int unsigned IN_BITS = 3;

    logic [IN_BITS-1:0] raw_in, sync_in;
    logic               shift_en, latch_en;
    logic [WIDTH-1:0]   shreg_q;

    assign raw_in = {ser_clk, ser_en, ser_in};

    cfg_sl_sync #(
        .BITS  (IN_BITS),
        .STAGES(cfg_sl_pkg::SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(raw_in),
        .sync_out(sync_in)
    );

    cfg_sl_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sync_in[2]),
        .en_s    (sync_in[1]),
        .shift_en(shift_en),
        .latch_en(latch_en)
    );

    cfg_sl_shreg #(.WIDTH(WIDTH)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .din     (sync_in[0]),
        .shreg_q (shreg_q),
        .dout    (ser_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cfg_word <= '0;
        else if (latch_en) cfg_word <= shreg_q;
    end

    // R4: the latch moves only on a commit
    p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> $stable(cfg_word));
    // R6: a commit copies the shift register
    p_latch_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |=> (cfg_word == $past(shreg_q)));

endmodule

// File: tb/tb_cfg_shift_latch.sv
module tb_cfg_shift_latch;

    localparam int unsigned W    = 22;
    localparam int unsigned NU   = 3;
    localparam int unsigned HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sen = 1'b0, sin = 1'b0;
    logic so0, so1, so2;
    logic [W-1:0] w0, w1, w2;
    logic [NU*W-1:0] model = '0;
    int checks = 0, failures = 0;
    bit done = 1'b0;
    bit watch_out = 1'b0;

    always #2.5 clk = ~clk;

    cfg_shift_latch #(.WIDTH(W)) dut    (.clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_en(sen),
                                         .ser_in(sin), .ser_out(so0), .cfg_word(w0));
    cfg_shift_latch #(.WIDTH(W)) chain1 (.clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_en(sen),
                                         .ser_in(so0), .ser_out(so1), .cfg_word(w1));
    cfg_shift_latch #(.WIDTH(W)) chain2 (.clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_en(sen),
                                         .ser_in(so1), .ser_out(so2), .cfg_word(w2));

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk_units(input string req);
        chk(req, w0, model[W-1:0]);
        chk(req, w1, model[2*W-1:W]);
        chk(req, w2, model[3*W-1:2*W]);
    endtask

    // one serial bit; R3: last unit's output shows the top model bit before the rise
    task automatic send_bit(input logic b);
        @(negedge clk);
        sin  = b;
        sclk = 1'b0;
        wait_neg(HALF);
        chk("R3 ser_out order", {{(W-1){1'b0}}, so2}, {{(W-1){1'b0}}, model[NU*W-1]});
        sclk = 1'b1;
        model = {model[NU*W-2:0], b};
        wait_neg(HALF);
        sclk = 1'b0;
    endtask

    task automatic open_en();
        @(negedge clk);
        sen = 1'b1;
        wait_neg(HALF);
    endtask

    task automatic close_en();
        @(negedge clk);
        sen = 1'b0;
        wait_neg(8);
    endtask

    function automatic logic [W-1:0] pat(input int k);
        return W'((k * 32'h0002_A5B3 + 32'h155 + (k << 7)) ^ (k * 32'h3_1F0F));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            watch_out = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] old0;
        // R1: reset state
        wait_neg(3);
        chk("R1 reset word", w0, '0);
        chk("R1 reset word", w2, '0);
        chk("R1 reset ser_out", {{(W-1){1'b0}}, so0 | so1 | so2}, '0);
        rst_n = 1'b1;
        wait_neg(4);
        chk("R1 after reset", w1, '0);

        // R2 R7 R3: sweep of chain loads, furthest unit's group first
        for (int r = 0; r < 6; r++) begin
            logic [W-1:0] g [NU];
            for (int u = 0; u < NU; u++) g[u] = pat(r * NU + u + 1);
            if (r == 5) begin g[0] = '1; g[1] = '0; g[2] = W'(1); end
            open_en();
            for (int u = NU - 1; u >= 0; u--)
                for (int b = W - 1; b >= 0; b--) send_bit(g[u][b]);
            close_en();
            chk("R2 MSB first unit0", w0, g[0]);
            chk("R7 chain unit1", w1, g[1]);
            chk("R7 chain unit2", w2, g[2]);
            chk_units("R7 model");
        end

        // R4: latch steady while shifting with enable high
        old0 = w0;
        open_en();
        for (int b = 0; b < 30; b++) begin
            send_bit(b[0] ^ b[2]);
            chk("R4 hold during load", w0, old0);
        end
        for (int b = 30; b < NU * W; b++) send_bit(b[1]);
        close_en();
        chk_units("R4 commit after load");

        // R5: serial clocks with enable low do nothing
        for (int b = 0; b < 5; b++) begin
            @(negedge clk); sin = 1'b1; sclk = 1'b0;
            wait_neg(HALF);
            sclk = 1'b1;
            wait_neg(HALF);
            chk("R5 ser_out steady", {{(W-1){1'b0}}, so2}, {{(W-1){1'b0}}, model[NU*W-1]});
        end
        sclk = 1'b0;
        wait_neg(HALF);
        open_en();
        close_en();
        chk_units("R5 empty commit");

        // R6: commit on the fourth clock edge after enable falls
        open_en();
        for (int b = 0; b < NU * W; b++) send_bit(~b[0]);
        old0 = w0;
        @(negedge clk);
        sen = 1'b0;
        repeat (3) @(posedge clk);
        #1 chk("R6 not yet at edge 3", w0, old0);
        @(posedge clk);
        #1 chk("R6 at edge 4", w0, model[W-1:0]);
        wait_neg(6);

        // R8: serial rise and enable fall together; rise dropped
        open_en();
        for (int b = 0; b < 5; b++) send_bit(b[0]);
        @(negedge clk);
        sin = 1'b1;
        sclk = 1'b0;
        wait_neg(HALF);
        sclk = 1'b1;
        sen  = 1'b0;
        wait_neg(10);
        sclk = 1'b0;
        wait_neg(HALF);
        chk_units("R8 dropped rise");

        done = 1'b1;
        if (!watch_out) begin
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule